// File: doc/BRIEF.md
# Scaled Load/Store Address Generator

This block turns one decoded compact load or store operation into a single memory access. It picks a base from a general register, the stack pointer or the program counter. It adds either a short unsigned offset, scaled by the access size, or a sign-extended 16-bit extended immediate, which is added without scaling. It then places the byte enables and the store data on a 64-bit little-endian bus. For loads, it waits for the returned data and extends the addressed bytes to a 64-bit write-back value. When the operation sits in a branch delay slot, a PC-relative base is taken from the saved branch address rather than from the current PC.

Operation is sequenced by a five-state machine. In `ST_IDLE` an operation is accepted when `op_valid` is high. The transition `accept_ok` goes to `ST_ISSUE`. The transition `accept_bad` goes to `ST_FAULT` when the computed address is not a multiple of the access size. `ST_ISSUE` drives the request for one cycle. From there, `issue_store` returns to `ST_IDLE` and `issue_load` moves to `ST_WAIT`. `ST_WAIT` holds until `data_back` (`ld_valid` high) moves it to `ST_WB`. `ST_WB` presents the write-back value for one cycle, then `wb_done` returns to `ST_IDLE`. `ST_FAULT` raises `misalign` for one cycle, then `fault_done` returns to `ST_IDLE`. The memory itself is outside the block.

Top module: `ls_addr_gen`

## Requirements
- R1: After reset `busy`, `mem_req`, `mem_we`, `misalign` and `wb_valid` are all low.
- R2: With `op_base`=00 (general register) and `op_ext`=0, the offset is `op_short[4:0]`, taken as unsigned and multiplied by the access size. `op_size` encodes the size as 0=byte(1), 1=halfword(2), 2=word(4), 3=doubleword(8). `op_short[7:5]` has no effect.
- R3: With `op_base`=01 (stack pointer) and `op_ext`=0, the offset is all 8 bits of `op_short`, unsigned and multiplied by the access size.
- R4: With `op_ext`=1, the offset is `op_imm` sign-extended from 16 bits and added unscaled, and `op_short` has no effect.
- R5: With `op_base`=10 (program counter), the base is the PC with its low `op_size` bits cleared.
- R6: With `op_base`=10 and `in_dslot`=1, `branch_pc` replaces `pc_cur` as the PC base.
- R7: With `op_ra`=1, the store data comes from `ra_val` instead of `st_val`.
- R8: If the address is not a multiple of the access size, `misalign` pulses for exactly one cycle, one cycle after acceptance, and no request is issued.
- R9: While `mem_req` is high, `mem_be` enables the access-size bytes starting at lane `mem_addr[2:0]`, and `mem_wdata` holds the low access-size bytes of the store value shifted to that lane, with other lanes zero. `mem_we` is high only for stores.
- R10: Byte, halfword and word loads sign-extend when `op_unsigned`=0 and zero-extend when it is 1. Doubleword loads pass all 64 bits unchanged.
- R11: `mem_req` is high for exactly the one cycle after acceptance. A load's `wb_valid` rises the cycle after `ld_valid` is seen in `ST_WAIT`. `op_valid` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation present this cycle |
| op_size | input | 2 | Access size: 0 byte, 1 half, 2 word, 3 double |
| op_store | input | 1 | 1 = store, 0 = load |
| op_unsigned | input | 1 | Zero-extend load data |
| op_base | input | 2 | Base: 00 register, 01 stack pointer, 10 PC |
| op_ext | input | 1 | Use the extended 16-bit immediate |
| op_ra | input | 1 | Store the return-address register |
| op_short | input | 8 | Short unsigned offset field |
| op_imm | input | 16 | Extended immediate |
| gpr_base | input | 64 | General-register base value |
| sp_val | input | 64 | Stack pointer value |
| ra_val | input | 64 | Return-address register value |
| st_val | input | 64 | Store source register value |
| pc_cur | input | 64 | Address of the current instruction |
| in_dslot | input | 1 | Instruction is in a branch delay slot |
| branch_pc | input | 64 | Address of the preceding branch |
| ld_valid | input | 1 | Load data returned |
| ld_data | input | 64 | Returned load data bus |
| busy | output | 1 | Operation in progress |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 64 | Effective address |
| mem_be | output | 8 | Byte enables |
| mem_wdata | output | 64 | Lane-placed store data |
| misalign | output | 1 | Misaligned access pulse |
| wb_valid | output | 1 | Write-back value valid |
| wb_data | output | 64 | Extended load result |

## Verification
The bench aims at three kinds of error. An offset handled the wrong way would make extended immediates scale, let the upper short bits leak into register-relative forms, or leave a stack-pointer offset unscaled; each of these would move the address by a visible amount. A PC base that is left unmasked, or that ignores the delay-slot flag, would give an address off by the low PC bits or pointing at the slot itself. Lane and extension mistakes are probed with data whose sign bit is set, in the upper lanes. A misaligned extended access is checked to fault without a request, and an operation offered while a load is outstanding is checked to be dropped.

// File: rtl/lsa_pkg.sv
package lsa_pkg;

    typedef enum logic [1:0] {
        SZ_B = 2'd0,
        SZ_H = 2'd1,
        SZ_W = 2'd2,
        SZ_D = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        BASE_GPR  = 2'd0,
        BASE_SP   = 2'd1,
        BASE_PC   = 2'd2,
        BASE_RSVD = 2'd3
    } base_sel_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_WB,
        ST_FAULT
    } agen_state_e;

endpackage

// File: rtl/lsa_addr_calc.sv
module lsa_addr_calc
    import lsa_pkg::*;
#(
    parameter int XLEN        = 64,
    parameter int SHORT_W     = 8,
    parameter int REG_SHORT_W = 5,
    parameter int IMM_W       = 16
) (
    input  acc_size_e          size,
    input  base_sel_e          base_sel,
    input  logic               use_ext,
    input  logic [SHORT_W-1:0] short_off,
    input  logic [IMM_W-1:0]   ext_imm,
    input  logic [XLEN-1:0]    gpr_base,
    input  logic [XLEN-1:0]    sp_val,
    input  logic [XLEN-1:0]    pc_cur,
    input  logic               in_dslot,
    input  logic [XLEN-1:0]    branch_pc,
    output logic [XLEN-1:0]    addr,
    output logic               misal
);
    localparam logic [XLEN-1:0] ONE = XLEN'(1);

    logic [XLEN-1:0] low_mask;
    logic [XLEN-1:0] pc_src;
    logic [XLEN-1:0] base;
    logic [XLEN-1:0] short_z;
    logic [XLEN-1:0] scaled;
    logic [XLEN-1:0] ext_off;

    // low bits that must be zero for the access size
    assign low_mask = (ONE << size) - ONE;

    // delay-slot instructions take the branch address as their PC
    assign pc_src = in_dslot ? branch_pc : pc_cur;

    always_comb begin
        unique case (base_sel)
            BASE_GPR: base = gpr_base;
            BASE_SP:  base = sp_val;
            BASE_PC:  base = pc_src & ~low_mask;
            default:  base = '0;
        endcase
    end

    // register-relative forms carry a narrower short field
    always_comb begin
        if (base_sel == BASE_GPR)
            short_z = XLEN'(short_off[REG_SHORT_W-1:0]);
        else
            short_z = XLEN'(short_off);
    end

    assign scaled  = short_z << size;
    assign ext_off = {{(XLEN-IMM_W){ext_imm[IMM_W-1]}}, ext_imm};

    assign addr  = base + (use_ext ? ext_off : scaled);
    assign misal = |(addr & low_mask);

endmodule

// File: rtl/lsa_lane.sv
module lsa_lane
    import lsa_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  acc_size_e                   size,
    input  logic [$clog2(XLEN/8)-1:0]   lane,
    input  logic [XLEN-1:0]             st_src,
    output logic [XLEN/8-1:0]           be,
    output logic [XLEN-1:0]             wdata
);
    localparam int NBYTES = XLEN / 8;
    localparam int LANE_W = $clog2(NBYTES);
    localparam int CW     = LANE_W + 2;

    logic [CW-1:0]   nbytes;
    logic [CW-1:0]   lane_end;
    logic [XLEN-1:0] keep_mask;

    assign nbytes   = CW'(1) << size;
    assign lane_end = CW'(lane) + nbytes;

    always_comb begin
        if (size == SZ_D)
            keep_mask = '1;
        else
            keep_mask = (XLEN'(1) << (nbytes * 8)) - XLEN'(1);
    end

    assign wdata = (st_src & keep_mask) << {lane, 3'b000};

    for (genvar g = 0; g < NBYTES; g++) begin : g_be
        assign be[g] = (CW'(g) >= CW'(lane)) && (CW'(g) < lane_end);
    end

endmodule

// File: rtl/lsa_load_ext.sv
module lsa_load_ext
    import lsa_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  acc_size_e                   size,
    input  logic                        uns,
    input  logic [$clog2(XLEN/8)-1:0]   lane,
    input  logic [XLEN-1:0]             ld_data,
    output logic [XLEN-1:0]             result
);
    localparam int BW = 8;
    localparam int HW = 16;
    localparam int WW = 32;

    logic [XLEN-1:0] shifted;
    logic            sb, sh, sw;

    assign shifted = ld_data >> {lane, 3'b000};
    assign sb = ~uns & shifted[BW-1];
    assign sh = ~uns & shifted[HW-1];
    assign sw = ~uns & shifted[WW-1];

    always_comb begin
        unique case (size)
            SZ_B:    result = {{(XLEN-BW){sb}}, shifted[BW-1:0]};
            SZ_H:    result = {{(XLEN-HW){sh}}, shifted[HW-1:0]};
            SZ_W:    result = {{(XLEN-WW){sw}}, shifted[WW-1:0]};
            default: result = shifted;
        endcase
    end

endmodule

// File: rtl/ls_addr_gen.sv
module ls_addr_gen
    import lsa_pkg::*;
#(
    parameter int XLEN        = 64,
    parameter int SHORT_W     = 8,
    parameter int REG_SHORT_W = 5,
    parameter int IMM_W       = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               op_valid,
    input  logic [1:0]         op_size,
    input  logic               op_store,
    input  logic               op_unsigned,
    input  logic [1:0]         op_base,
    input  logic               op_ext,
    input  logic               op_ra,
    input  logic [SHORT_W-1:0] op_short,
    input  logic [IMM_W-1:0]   op_imm,
    input  logic [XLEN-1:0]    gpr_base,
    input  logic [XLEN-1:0]    sp_val,
    input  logic [XLEN-1:0]    ra_val,
    input  logic [XLEN-1:0]    st_val,
    input  logic [XLEN-1:0]    pc_cur,
    input  logic               in_dslot,
    input  logic [XLEN-1:0]    branch_pc,
    input  logic               ld_valid,
    input  logic [XLEN-1:0]    ld_data,
    output logic               busy,
    output logic               mem_req,
    output logic               mem_we,
    output logic [XLEN-1:0]    mem_addr,
    output logic [XLEN/8-1:0]  mem_be,
    output logic [XLEN-1:0]    mem_wdata,
    output logic               misalign,
    output logic               wb_valid,
    output logic [XLEN-1:0]    wb_data
);
    localparam int NBYTES = XLEN / 8;
    localparam int LANE_W = $clog2(NBYTES);

    agen_state_e state, state_nx;

    acc_size_e         size_in, size_q;
    logic [XLEN-1:0]   addr_c, addr_q;
    logic              misal_c;
    logic [NBYTES-1:0] be_c, be_q;
    logic [XLEN-1:0]   wdata_c, wdata_q;
    logic [XLEN-1:0]   st_src;
    logic              store_q, uns_q;
    logic [XLEN-1:0]   ext_c, wb_q;
    logic              accept;

    assign size_in = acc_size_e'(op_size);
    assign st_src  = op_ra ? ra_val : st_val;
    assign accept  = op_valid && (state == ST_IDLE);

    lsa_addr_calc #(
        .XLEN(XLEN), .SHORT_W(SHORT_W),
        .REG_SHORT_W(REG_SHORT_W), .IMM_W(IMM_W)
    ) u_calc (
        .size      (size_in),
        .base_sel  (base_sel_e'(op_base)),
        .use_ext   (op_ext),
        .short_off (op_short),
        .ext_imm   (op_imm),
        .gpr_base  (gpr_base),
        .sp_val    (sp_val),
        .pc_cur    (pc_cur),
        .in_dslot  (in_dslot),
        .branch_pc (branch_pc),
        .addr      (addr_c),
        .misal     (misal_c)
    );

    lsa_lane #(.XLEN(XLEN)) u_lane (
        .size   (size_in),
        .lane   (addr_c[LANE_W-1:0]),
        .st_src (st_src),
        .be     (be_c),
        .wdata  (wdata_c)
    );

    lsa_load_ext #(.XLEN(XLEN)) u_ext (
        .size    (size_q),
        .uns     (uns_q),
        .lane    (addr_q[LANE_W-1:0]),
        .ld_data (ld_data),
        .result  (ext_c)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (accept) state_nx = misal_c ? ST_FAULT : ST_ISSUE;
            ST_ISSUE: state_nx = store_q ? ST_IDLE : ST_WAIT;
            ST_WAIT:  if (ld_valid) state_nx = ST_WB;
            ST_WB:    state_nx = ST_IDLE;
            ST_FAULT: state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // captured operation and load result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            be_q    <= '0;
            wdata_q <= '0;
            size_q  <= SZ_B;
            store_q <= 1'b0;
            uns_q   <= 1'b0;
            wb_q    <= '0;
        end else begin
            if (accept) begin
                addr_q  <= addr_c;
                be_q    <= be_c;
                wdata_q <= op_store ? wdata_c : '0;
                size_q  <= size_in;
                store_q <= op_store;
                uns_q   <= op_unsigned;
            end
            if (state == ST_WAIT && ld_valid)
                wb_q <= ext_c;
        end
    end

    // outputs
    always_comb begin
        busy      = (state != ST_IDLE);
        mem_req   = (state == ST_ISSUE);
        mem_we    = (state == ST_ISSUE) && store_q;
        mem_addr  = addr_q;
        mem_be    = (state == ST_ISSUE) ? be_q : '0;
        mem_wdata = wdata_q;
        misalign  = (state == ST_FAULT);
        wb_valid  = (state == ST_WB);
        wb_data   = (state == ST_WB) ? wb_q : '0;
    end

    // R11
    req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    // R11
    wb_after_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> $past(ld_valid));

    // R8
    fault_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |=> (!misalign && !mem_req));

    // R8
    aligned_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> ((mem_addr & ((XLEN'(1) << size_q) - XLEN'(1))) == '0));

    // R9
    be_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> ($countones(mem_be) == (1 << size_q)));

    // R9
    be_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_be[mem_addr[LANE_W-1:0]]);

endmodule

// File: tb/ls_addr_gen_bench.sv
module ls_addr_gen_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [1:0]  op_size = '0;
    logic        op_store = 1'b0;
    logic        op_unsigned = 1'b0;
    logic [1:0]  op_base = '0;
    logic        op_ext = 1'b0;
    logic        op_ra = 1'b0;
    logic [7:0]  op_short = '0;
    logic [15:0] op_imm = '0;
    logic [63:0] gpr_base = '0, sp_val = '0, ra_val = '0, st_val = '0;
    logic [63:0] pc_cur = '0, branch_pc = '0, ld_data = '0;
    logic        in_dslot = 1'b0;
    logic        ld_valid = 1'b0;
    logic        busy, mem_req, mem_we, misalign, wb_valid;
    logic [63:0] mem_addr, mem_wdata, wb_data;
    logic [7:0]  mem_be;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    ls_addr_gen u_ls_addr_gen (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_size(op_size),
        .op_store(op_store), .op_unsigned(op_unsigned), .op_base(op_base),
        .op_ext(op_ext), .op_ra(op_ra), .op_short(op_short), .op_imm(op_imm),
        .gpr_base(gpr_base), .sp_val(sp_val), .ra_val(ra_val), .st_val(st_val),
        .pc_cur(pc_cur), .in_dslot(in_dslot), .branch_pc(branch_pc),
        .ld_valid(ld_valid), .ld_data(ld_data), .busy(busy), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .misalign(misalign), .wb_valid(wb_valid),
        .wb_data(wb_data)
    );

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic set_op(input logic [1:0] sz, input logic st, input logic uns,
                          input logic [1:0] bs, input logic ext, input logic ra,
                          input logic [7:0] sh, input logic [15:0] imm);
        op_size = sz; op_store = st; op_unsigned = uns; op_base = bs;
        op_ext = ext; op_ra = ra; op_short = sh; op_imm = imm;
    endtask

    // offer the operation for one cycle; returns at the negedge of ST_ISSUE
    task automatic fire();
        op_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    // from ST_ISSUE of a load: return data, end at the negedge of ST_WB
    task automatic give_data(input logic [63:0] d);
        @(posedge clk);
        @(negedge clk);
        ld_valid = 1'b1; ld_data = d;
        @(posedge clk);
        @(negedge clk);
        ld_valid = 1'b0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 busy", 64'(busy), 0);
        check("R1 mem_req", 64'(mem_req), 0);
        check("R1 mem_we", 64'(mem_we), 0);
        check("R1 misalign", 64'(misalign), 0);
        check("R1 wb_valid", 64'(wb_valid), 0);
    endtask

    task automatic t_reg_byte_store();
        gpr_base = 64'h1000; st_val = 64'h1122334455667788;
        set_op(2'd0, 1, 0, 2'b00, 0, 0, 8'hE3, 16'h0);  // upper short bits ignored
        fire();
        check("R2 byte addr", mem_addr, 64'h1003);
        check("R11 req", 64'(mem_req), 1);
        check("R9 we", 64'(mem_we), 1);
        check("R9 be", 64'(mem_be), 64'h08);
        check("R9 wdata", mem_wdata, 64'h0000_0000_8800_0000);
        step();
        check("R11 req drop", 64'(mem_req), 0);
        check("R11 store idle", 64'(busy), 0);
    endtask

    task automatic t_reg_half_load(input logic uns, input logic [63:0] exp);
        gpr_base = 64'h2000;
        set_op(2'd1, 0, uns, 2'b00, 0, 0, 8'h05, 16'h0);
        fire();
        check("R2 half addr", mem_addr, 64'h200A);
        check("R9 half be", 64'(mem_be), 64'h0C);
        check("R9 load we", 64'(mem_we), 0);
        give_data(64'h0000_0000_8001_0000);
        check("R11 wb_valid", 64'(wb_valid), 1);
        check("R10 half ext", wb_data, exp);
        step();
    endtask

    task automatic t_sp_word_load(input logic uns, input logic [63:0] exp);
        sp_val = 64'h8000;
        set_op(2'd2, 0, uns, 2'b01, 0, 0, 8'hFF, 16'h0);
        fire();
        check("R3 sp word addr", mem_addr, 64'h83FC);
        check("R9 word be", 64'(mem_be), 64'hF0);
        give_data(64'h8765_4321_0000_0000);
        check("R10 word ext", wb_data, exp);
        step();
    endtask

    task automatic t_sp_dword_store();
        sp_val = 64'h8000; st_val = 64'hCAFE_F00D_1234_5678;
        set_op(2'd3, 1, 0, 2'b01, 0, 0, 8'h10, 16'h0);
        fire();
        check("R3 sp dword addr", mem_addr, 64'h8080);
        check("R9 dword be", 64'(mem_be), 64'hFF);
        check("R9 dword wdata", mem_wdata, 64'hCAFE_F00D_1234_5678);
        step();
    endtask

    task automatic t_ext();
        gpr_base = 64'h5000;
        set_op(2'd0, 0, 0, 2'b00, 1, 0, 8'h1F, 16'hFFF0);  // short ignored
        fire();
        check("R4 ext neg addr", mem_addr, 64'h4FF0);
        give_data(64'hFFFF_FFFF_FFFF_FF7F);
        check("R10 byte signed pos", wb_data, 64'h7F);
        step();
        gpr_base = 64'h100;
        set_op(2'd3, 1, 0, 2'b00, 1, 0, 8'h1F, 16'h0008);
        fire();
        check("R4 ext unscaled addr", mem_addr, 64'h108);
        step();
    endtask

    task automatic t_pc();
        pc_cur = 64'h1236; in_dslot = 0;
        set_op(2'd2, 0, 0, 2'b10, 0, 0, 8'h03, 16'h0);
        fire();
        check("R5 pc word addr", mem_addr, 64'h1240);
        give_data(64'h0);
        step();
        set_op(2'd3, 0, 0, 2'b10, 0, 0, 8'h01, 16'h0);
        fire();
        check("R5 pc dword addr", mem_addr, 64'h1238);
        // R11: offered while busy, must be dropped
        @(posedge clk);
        @(negedge clk);
        set_op(2'd0, 1, 0, 2'b00, 0, 0, 8'h00, 16'h0);
        op_valid = 1'b1;
        check("R11 busy in wait", 64'(busy), 1);
        ld_valid = 1'b1; ld_data = 64'hA5A5_0000_1234_5678;
        @(posedge clk);
        @(negedge clk);
        ld_valid = 1'b0; op_valid = 1'b0;
        check("R10 dword pass", wb_data, 64'hA5A5_0000_1234_5678);
        step();
        check("R11 ignored no busy", 64'(busy), 0);
        step();
        check("R11 ignored no req", 64'(mem_req), 0);
    endtask

    task automatic t_dslot();
        pc_cur = 64'h9000; in_dslot = 1; branch_pc = 64'h4006;
        set_op(2'd2, 0, 0, 2'b10, 0, 0, 8'h00, 16'h0);
        fire();
        check("R6 dslot addr", mem_addr, 64'h4004);
        give_data(64'h0);
        step();
        in_dslot = 0;
    endtask

    task automatic t_ra_store();
        sp_val = 64'h8000; ra_val = 64'hDEAD_BEEF_0000_1111; st_val = 64'h9999_9999_9999_9999;
        set_op(2'd2, 1, 0, 2'b01, 0, 1, 8'h01, 16'h0);
        fire();
        check("R7 ra addr", mem_addr, 64'h8004);
        check("R7 ra wdata", mem_wdata, 64'h0000_1111_0000_0000);
        check("R9 ra be", 64'(mem_be), 64'hF0);
        step();
    endtask

    task automatic t_misalign();
        gpr_base = 64'h100;
        set_op(2'd2, 0, 0, 2'b00, 1, 0, 8'h00, 16'h0002);
        fire();
        check("R8 misalign pulse", 64'(misalign), 1);
        check("R8 no req", 64'(mem_req), 0);
        step();
        check("R8 pulse ends", 64'(misalign), 0);
        check("R8 idle after", 64'(busy), 0);
        check("R8 still no req", 64'(mem_req), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got hung expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_reg_byte_store();
        t_reg_half_load(0, 64'hFFFF_FFFF_FFFF_8001);
        t_reg_half_load(1, 64'h0000_0000_0000_8001);
        t_sp_word_load(0, 64'hFFFF_FFFF_8765_4321);
        t_sp_word_load(1, 64'h0000_0000_8765_4321);
        t_sp_dword_store();
        t_ext();
        t_pc();
        t_dslot();
        t_ra_store();
        t_misalign();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule